// File: doc/BRIEF.md
# SPI Slave Host Control Port

This block lets an external host controller exchange command and data bytes with the device over a four-wire serial link. The device acts only as the slave. Every transfer opens with a header byte. The header carries a 7-bit device address in its upper bits and a direction flag in bit 0. Data bytes follow, most significant bit first. A write transfer whose address matches places each complete byte into a 16-entry receive buffer, and core logic drains that buffer. A read transfer shifts out bytes that the core presents through a show-ahead output buffer interface. The port takes a byte from that interface only after all of its bits have left on MISO.

Chip-select, serial clock and MOSI are brought into the core clock domain through two-flop synchronizers and edge detectors. For this reason the core clock must run at least four times as fast as the serial clock. An active-low busy line tells the host to pause before the receive buffer overflows. An interrupt line tells the host that the device has outgoing data. The MISO driver is enabled only during a matched read.

Top module: `spi_host_port`

## Requirements
- R1: In the header byte, bits 7..1 are the device address and bit 0 is the direction (1 = read, 0 = write). After a matching write header, each following byte is taken MSB first and appears on `rx_data` in the order it was sent.
- R2: A transfer whose header address differs from `DEV_ADDR` has no effect. No byte is stored, `miso_oe` stays low and `tx_pop` never pulses.
- R3: The receive buffer holds 16 bytes. `rx_valid` is high while it is not empty, and `rx_ready` removes the head entry. A byte that arrives while the buffer is full is dropped.
- R4: `busy_n` is low while 2 or fewer receive entries are free, and high otherwise.
- R5: After a matching read header, `miso_oe` is high and each data byte carries `tx_data` MSB first. `tx_pop` pulses once for each byte whose eight bits have all been shifted out. When `tx_avail` is low at the start of a byte, 0x00 is sent and no pop follows.
- R6: MISO changes only after a falling serial clock edge. It is stable while the serial clock is high.
- R7: While chip-select is high, `miso_oe` is low (MISO is high impedance).
- R8: `irq` rises after a falling serial clock edge of a selected transfer while `tx_avail` is high. It drops after chip-select rises.
- R9: When chip-select rises in the middle of a byte, the partial byte is discarded and the bit counter is cleared, so the next transfer decodes a fresh header.
- R10: After reset, `miso_oe`, `irq`, `rx_valid` and `tx_pop` are low and `busy_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip-select from host, active low |
| sclk | input | 1 | Serial clock from host, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| busy_n | output | 1 | Flow control, low when receive buffer is near full |
| irq | output | 1 | Outgoing data pending |
| rx_data | output | 8 | Head of the receive buffer |
| rx_valid | output | 1 | Receive buffer not empty |
| rx_ready | input | 1 | Removes the head byte of the receive buffer |
| tx_data | input | 8 | Head byte of the core's output buffer |
| tx_avail | input | 1 | Output buffer holds a byte |
| tx_pop | output | 1 | One-cycle pulse: head byte fully sent |

## Verification
Several properties are checked on every cycle. MISO holds its value unless a falling clock edge was detected. The pad driver stays off once chip-select has been high for the synchronizer depth. The interrupt drops after a chip-select rise. Busy is already low when the buffer nears full, and an ignored transfer never drives MISO or pops data. Byte ordering, header decoding and the discarding of aborted partial bytes cannot be seen from single-cycle relations, so only the bench scenarios show them. The same holds for the exact number of pops on a read that runs past the available data.

// File: rtl/spi_host_port.sv
module spi_host_port #(
  parameter logic [6:0] DEV_ADDR  = 7'h2C,
  parameter int         DEPTH     = 16,
  parameter int         BUSY_FREE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  output logic       busy_n,
  output logic       irq,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_avail,
  output logic       tx_pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_HDR, S_WR, S_RD, S_SKIP} st_t;

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire sel      = ~cs_q[1];
  wire cs_rise  = cs_q[1] & ~cs_q[2];

  st_t        st;
  logic [2:0] bit_cnt;
  logic [6:0] sh_in;
  logic [7:0] sh_out;
  logic       ld_real;

  wire [7:0] byte_in   = {sh_in, mosi_q[1]};
  wire       byte_done = sel & sck_rise & (bit_cnt == 3'd7);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire push = byte_done & (st == S_WR) & (count != CW'(DEPTH));
  wire pop  = rx_ready & (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_HDR;
      bit_cnt <= '0;
      sh_in   <= '0;
      sh_out  <= '0;
      ld_real <= 1'b0;
      tx_pop  <= 1'b0;
    end else begin
      tx_pop <= 1'b0;
      if (!sel) begin
        st      <= S_HDR;
        bit_cnt <= '0;
        ld_real <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          sh_in   <= byte_in[6:0];
          if (bit_cnt == 3'd7) begin
            if (st == S_HDR)
              st <= (byte_in[7:1] != DEV_ADDR) ? S_SKIP : (byte_in[0] ? S_RD : S_WR);
            if (st == S_RD && ld_real)
              tx_pop <= 1'b1;
          end
        end
        if (sck_fall && st == S_RD) begin
          if (bit_cnt == 3'd0) begin
            sh_out  <= tx_avail ? tx_data : 8'h00;
            ld_real <= tx_avail;
          end else begin
            sh_out  <= {sh_out[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          irq <= 1'b0;
    else if (cs_rise)                    irq <= 1'b0;
    else if (sel && sck_fall && tx_avail) irq <= 1'b1;
  end

  assign miso    = sh_out[7];
  assign miso_oe = sel & (st == S_RD);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      busy_n <= 1'b1;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      busy_n <= (CW'(DEPTH) - count) > CW'(BUSY_FREE);
    end
  end

  assign rx_data  = mem[rd_ptr];
  assign rx_valid = (count != '0);
endmodule

// File: rtl/spi_host_port_chk.sv
module spi_host_port_chk #(
  parameter int DEPTH     = 16,
  parameter int BUSY_FREE = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       miso,
  input logic                       miso_oe,
  input logic                       busy_n,
  input logic                       irq,
  input logic                       tx_pop,
  input logic                       sck_fall,
  input logic                       cs_rise,
  input logic                       in_skip,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(miso)); // R6
  AST_MISO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso_oe); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !irq); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH)); // R3
  AST_BUSY_BEFORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= ($clog2(DEPTH+1))'(DEPTH - BUSY_FREE + 1)) |-> !busy_n); // R4
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> (!miso_oe && !tx_pop)); // R2
endmodule

bind spi_host_port spi_host_port_chk #(.DEPTH(DEPTH), .BUSY_FREE(BUSY_FREE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
  .busy_n(busy_n), .irq(irq), .tx_pop(tx_pop), .sck_fall(sck_fall),
  .cs_rise(cs_rise), .in_skip(st == S_SKIP), .count(count)
);

// File: tb/tb_spi_host_port.sv
module tb_spi_host_port;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, mosi = 0, rx_ready = 0;
  logic miso, miso_oe, busy_n, irq, rx_valid, tx_pop;
  logic [7:0] rx_data, tx_data;
  logic tx_avail;
  logic [7:0] txq [4];
  int tx_n = 0, tx_base = 0, tx_pops = 0;
  int checks = 0, errors = 0, r6_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_host_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .busy_n(busy_n), .irq(irq),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_avail(tx_avail), .tx_pop(tx_pop)
  );

  assign tx_avail = (tx_pops - tx_base) < tx_n;
  assign tx_data  = ((tx_pops - tx_base) < 4) ? txq[tx_pops - tx_base] : 8'h00;
  always @(negedge clk) if (tx_pop) tx_pops++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic hold;
      mosi = b[i];
      half();
      r[i] = miso;
      hold = miso;
      sclk = 1;
      half();
      if (miso_oe && miso !== hold) r6_bad++;
      sclk = 0;
    end
  endtask

  task automatic start();
    cs_n = 0; half();
  endtask

  task automatic stop();
    half(); cs_n = 1; half(); half();
  endtask

  task automatic pop_rx(output logic [7:0] d);
    @(negedge clk); d = rx_data; rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic t_reset();
    chk("R10 miso_oe", miso_oe, 0);
    chk("R10 irq", irq, 0);
    chk("R10 rx_valid", rx_valid, 0);
    chk("R10 tx_pop", tx_pop, 0);
    chk("R10 busy_n", busy_n, 1);
  endtask

  task automatic t_write();
    logic [7:0] r, d;
    start();
    xfer({ADDR, 1'b0}, r);
    xfer(8'h81, r); xfer(8'h3F, r); xfer(8'hC2, r);
    stop();
    chk("R3 rx_valid after write", rx_valid, 1);
    pop_rx(d); chk("R1 byte0", d, 8'h81);
    pop_rx(d); chk("R1 byte1", d, 8'h3F);
    pop_rx(d); chk("R1 byte2", d, 8'hC2);
    chk("R3 empty after drain", rx_valid, 0);
  endtask

  task automatic t_mismatch();
    logic [7:0] r;
    int p0;
    start();
    xfer({7'h3A, 1'b0}, r); xfer(8'h55, r);
    stop();
    chk("R2 write ignored", rx_valid, 0);
    tx_base = tx_pops; txq[0] = 8'h99; tx_n = 1; p0 = tx_pops;
    start();
    xfer({7'h2D, 1'b1}, r);
    chk("R2 miso_oe off", miso_oe, 0);
    xfer(8'h00, r);
    stop();
    chk("R2 no pop", tx_pops - p0, 0);
    tx_n = 0;
  endtask

  task automatic t_fill();
    logic [7:0] r, d;
    start();
    xfer({ADDR, 1'b0}, r);
    for (int i = 0; i < 20; i++) begin
      xfer(8'h10 + 8'(i), r);
      if (i == 12) chk("R4 busy_n high with 3 free", busy_n, 1);
      if (i == 13) chk("R4 busy_n low with 2 free", busy_n, 0);
    end
    stop();
    for (int i = 0; i < 16; i++) begin
      pop_rx(d);
      chk("R3 kept first 16", d, 8'h10 + 8'(i));
    end
    chk("R3 overflow bytes dropped", rx_valid, 0);
    repeat (2) @(negedge clk);
    chk("R4 busy_n released", busy_n, 1);
  endtask

  task automatic t_read();
    logic [7:0] r;
    int p0;
    tx_base = tx_pops; txq[0] = 8'hA5; txq[1] = 8'h3C; tx_n = 2; p0 = tx_pops;
    start();
    xfer({ADDR, 1'b1}, r);
    chk("R5 miso_oe on", miso_oe, 1);
    chk("R8 irq raised", irq, 1);
    xfer(8'h00, r); chk("R5 read byte0", r, 8'hA5);
    xfer(8'h00, r); chk("R5 read byte1", r, 8'h3C);
    xfer(8'h00, r); chk("R5 empty sends zero", r, 8'h00);
    stop();
    chk("R5 pop count", tx_pops - p0, 2);
    chk("R7 miso_oe off after cs", miso_oe, 0);
    chk("R8 irq dropped", irq, 0);
    chk("R6 miso stable while sclk high", r6_bad, 0);
    tx_n = 0;
  endtask

  task automatic t_abort();
    logic [7:0] r, d;
    logic [7:0] h;
    h = {ADDR, 1'b0};
    start();
    for (int i = 7; i >= 3; i--) begin
      mosi = h[i]; half(); sclk = 1; half(); sclk = 0;
    end
    stop();
    chk("R9 partial discarded", rx_valid, 0);
    start();
    xfer({ADDR, 1'b0}, r); xfer(8'h77, r);
    stop();
    chk("R9 fresh header decoded", rx_valid, 1);
    pop_rx(d); chk("R9 byte after abort", d, 8'h77);
    chk("R9 only one byte", rx_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_mismatch();
    t_fill();
    t_read();
    t_abort();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end
endmodule